// File: doc/BRIEF.md
# Addressing Byte Length Resolver

This block sits in an instruction decoder at the point where the addressing-form byte has just been fetched. It looks at that byte, the effective address width, the opcode map and the opcode. From these it works out how many displacement bytes follow, whether a scale-index-base byte comes next, and which collection phase the decoder enters next. It can also raise the pending immediate length for the one-byte-map test-style opcodes.

It works in two steps. An addressing byte presented with `mrm_vld` produces a registered result one cycle later. If that result points at the scale-index-base phase, the decoder presents that byte with `sib_vld`. The block then refines the displacement length, using the no-base encoding, and selects the next phase again. The addressing byte is always latched and shown on `mrm_q`. Fetching the displacement and immediate bytes is left to the surrounding decoder.

Top module: `mrm_len_resolver`

## Requirements
- R1: With `addr_sz`=0 (16-bit), the displacement is 2 bytes when mod (bits 7:6)=2, or when mod=0 with rm (bits 2:0)=6. It is 1 byte when mod=1 and 0 bytes otherwise.
- R2: With `addr_sz`=1 or 2 (32/64-bit), the displacement is 4 bytes when mod=2, or when mod=0 with rm=5. It is 1 byte when mod=1 and 0 bytes otherwise.
- R3: `sib_next` is set after an addressing byte only when rm=4, mod is not 3 and `addr_sz` is not 0.
- R4: A scale-index-base byte whose base field (bits 2:0) is 5 forces the displacement to 4 bytes when the latched mod is 0. In every other case the displacement from the addressing byte is kept. `sib_next` then reads 0.
- R5: When `op_map`=0, the opcode is F6h and reg bits 5:4 of the addressing byte are 00, the immediate length becomes 1.
- R6: When `op_map`=0, the opcode is F7h and reg bits 5:4 are 00, the immediate length becomes `opnd_sz`, or 4 when `opnd_sz` is 8. In all other cases `imm_len` equals `imm_in`.
- R7: `phase` encodes 0=done, 1=SIB, 2=displacement, 3=immediate. After the addressing byte it is 1 if `sib_next`. Otherwise it is 2 if the displacement is nonzero, then 3 if the immediate is nonzero, else 0. After the SIB byte the same order applies without the SIB choice.
- R8: Each accepted byte gives `out_vld` high for exactly one cycle, one clock later. `mrm_q` then holds the addressing byte, whichever phase follows.
- R9: After reset all outputs are 0. A `sib_vld` while `phase` is not 1 (or together with `mrm_vld`) is ignored: the outputs keep their values and `out_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrm_vld | input | 1 | Addressing byte present |
| mrm_byte | input | 8 | Addressing byte |
| sib_vld | input | 1 | Scale-index-base byte present |
| sib_byte | input | 8 | Scale-index-base byte |
| addr_sz | input | 2 | Address width: 0=16, 1=32, 2=64 bit |
| op_map | input | 2 | Opcode map, 0 = one-byte map |
| opcode | input | 8 | Opcode byte |
| opnd_sz | input | 4 | Operand size in bytes (1, 2, 4, 8) |
| imm_in | input | 4 | Pending immediate length in bytes |
| disp_len | output | 4 | Displacement length in bytes |
| sib_next | output | 1 | A scale-index-base byte follows |
| imm_len | output | 4 | Possibly adjusted immediate length |
| phase | output | 2 | Next collection phase |
| out_vld | output | 1 | Result updated this cycle |
| mrm_q | output | 8 | Latched addressing byte |

## Verification
Random addressing bytes are drawn over all three address widths, so the 16-bit table is told apart from the 32/64-bit one, with rm=4 and rm=5/6 coming up often. Opcodes are biased toward F6h and F7h under every map and reg value. This separates the test-style widening from pass-through, including the 8-byte operand cap. Scale-index-base bytes follow whenever the phase asks for one, with base 5 under each mod value. Directed cases cover reset, a stray SIB strobe in a non-SIB phase, and a stray strobe that arrives together with an addressing byte.

// File: rtl/mrm_len_pkg.sv
package mrm_len_pkg;
  localparam int LEN_W = 4;
  typedef enum logic [1:0] {
    PH_DONE = 2'd0,
    PH_SIB  = 2'd1,
    PH_DISP = 2'd2,
    PH_IMM  = 2'd3
  } phase_e;
  localparam logic [1:0] ASZ_16 = 2'd0;
endpackage

// File: rtl/mrm_disp_dec.sv
module mrm_disp_dec #(
  parameter int LEN_W = 4
) (
  input  logic [1:0]       md,
  input  logic [2:0]       rm,
  input  logic             a16,
  output logic [LEN_W-1:0] disp,
  output logic             has_sib
);
  localparam logic [LEN_W-1:0] L0 = '0;
  localparam logic [LEN_W-1:0] L1 = LEN_W'(1);
  localparam logic [LEN_W-1:0] L2 = LEN_W'(2);
  localparam logic [LEN_W-1:0] L4 = LEN_W'(4);

  always_comb begin
    if (a16) begin
      if ((md == 2'd0 && rm == 3'd6) || md == 2'd2) disp = L2;
      else if (md == 2'd1)                          disp = L1;
      else                                          disp = L0;
    end else begin
      if ((md == 2'd0 && rm == 3'd5) || md == 2'd2) disp = L4;
      else if (md == 2'd1)                          disp = L1;
      else                                          disp = L0;
    end
    has_sib = (rm == 3'd4) && (md != 2'd3) && !a16;
  end
endmodule

// File: rtl/grp3_imm_fix.sv
module grp3_imm_fix #(
  parameter int LEN_W = 4
) (
  input  logic             one_byte_map,
  input  logic [7:0]       opc,
  input  logic [1:0]       reg_hi,
  input  logic [LEN_W-1:0] opnd,
  input  logic [LEN_W-1:0] imm_i,
  output logic [LEN_W-1:0] imm_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(4);
  localparam logic [LEN_W-1:0] WIDE = LEN_W'(8);

  always_comb begin
    imm_o = imm_i;
    if (one_byte_map && reg_hi == 2'b00) begin
      if (opc == 8'hF6)      imm_o = LEN_W'(1);
      else if (opc == 8'hF7) imm_o = (opnd == WIDE) ? CAP : opnd;
    end
  end
endmodule

// File: rtl/phase_pick.sv
module phase_pick
  import mrm_len_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             want_sib,
  input  logic [LEN_W-1:0] disp,
  input  logic [LEN_W-1:0] imm,
  output phase_e           nxt
);
  always_comb begin
    if (want_sib)        nxt = PH_SIB;
    else if (disp != '0) nxt = PH_DISP;
    else if (imm != '0)  nxt = PH_IMM;
    else                 nxt = PH_DONE;
  end
endmodule

// File: rtl/mrm_len_resolver.sv
module mrm_len_resolver
  import mrm_len_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LW     = LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrm_vld,
  input  logic [BYTE_W-1:0] mrm_byte,
  input  logic              sib_vld,
  input  logic [BYTE_W-1:0] sib_byte,
  input  logic [1:0]        addr_sz,
  input  logic [1:0]        op_map,
  input  logic [7:0]        opcode,
  input  logic [LW-1:0]     opnd_sz,
  input  logic [LW-1:0]     imm_in,
  output logic [LW-1:0]     disp_len,
  output logic              sib_next,
  output logic [LW-1:0]     imm_len,
  output logic [1:0]        phase,
  output logic              out_vld,
  output logic [BYTE_W-1:0] mrm_q
);
  localparam logic [2:0] NOBASE = 3'd5;

  logic [LW-1:0] m_disp, m_imm, s_disp;
  logic          m_sib;
  phase_e        m_ph, s_ph;
  logic          sib_take;
  logic          unused_sib_hi;

  assign unused_sib_hi = ^sib_byte[BYTE_W-1:3];

  mrm_disp_dec #(.LEN_W(LW)) u_disp (
    .md(mrm_byte[7:6]), .rm(mrm_byte[2:0]), .a16(addr_sz == ASZ_16),
    .disp(m_disp), .has_sib(m_sib)
  );

  grp3_imm_fix #(.LEN_W(LW)) u_imm (
    .one_byte_map(op_map == 2'd0), .opc(opcode), .reg_hi(mrm_byte[5:4]),
    .opnd(opnd_sz), .imm_i(imm_in), .imm_o(m_imm)
  );

  phase_pick #(.LEN_W(LW)) u_ph_m (
    .want_sib(m_sib), .disp(m_disp), .imm(m_imm), .nxt(m_ph)
  );

  assign s_disp = (mrm_q[7:6] == 2'd0 && sib_byte[2:0] == NOBASE) ? LW'(4) : disp_len;

  phase_pick #(.LEN_W(LW)) u_ph_s (
    .want_sib(1'b0), .disp(s_disp), .imm(imm_len), .nxt(s_ph)
  );

  assign sib_take = sib_vld && !mrm_vld && (phase == PH_SIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_len <= '0;
      sib_next <= 1'b0;
      imm_len  <= '0;
      phase    <= PH_DONE;
      out_vld  <= 1'b0;
      mrm_q    <= '0;
    end else begin
      out_vld <= mrm_vld || sib_take;
      if (mrm_vld) begin
        disp_len <= m_disp;
        sib_next <= m_sib;
        imm_len  <= m_imm;
        phase    <= m_ph;
        mrm_q    <= mrm_byte;
      end else if (sib_take) begin
        disp_len <= s_disp;
        sib_next <= 1'b0;
        phase    <= s_ph;
      end
    end
  end
endmodule

// File: rtl/mrm_len_checks.sv
module mrm_len_checks #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mrm_vld,
  input logic [7:0]    mrm_byte,
  input logic          sib_vld,
  input logic [7:0]    sib_byte,
  input logic [1:0]    addr_sz,
  input logic [LW-1:0] disp_len,
  input logic          sib_next,
  input logic [LW-1:0] imm_len,
  input logic [1:0]    phase,
  input logic          out_vld,
  input logic [7:0]    mrm_q
);
  // R8
  latch_byte_chk: assert property (@(posedge clk) disable iff (rst)
    mrm_vld |=> (out_vld && mrm_q == $past(mrm_byte)));

  // R3
  no_sib16_chk: assert property (@(posedge clk) disable iff (rst)
    (mrm_vld && addr_sz == 2'd0) |=> !sib_next);

  // R4
  nobase_force_chk: assert property (@(posedge clk) disable iff (rst)
    (sib_vld && !mrm_vld && phase == 2'd1 && mrm_q[7:6] == 2'd0 && sib_byte[2:0] == 3'd5)
      |=> (disp_len == LW'(4) && !sib_next));

  // R7
  disp_first_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !sib_next && disp_len != '0) |-> phase == 2'd2);

  // R7
  sib_phase_chk: assert property (@(posedge clk) disable iff (rst)
    sib_next |-> phase == 2'd1);

  // R9
  stray_sib_chk: assert property (@(posedge clk) disable iff (rst)
    (sib_vld && !mrm_vld && phase != 2'd1)
      |=> (!out_vld && $stable(disp_len) && $stable(imm_len) && $stable(phase)));
endmodule

bind mrm_len_resolver mrm_len_checks #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .mrm_vld(mrm_vld), .mrm_byte(mrm_byte),
  .sib_vld(sib_vld), .sib_byte(sib_byte), .addr_sz(addr_sz),
  .disp_len(disp_len), .sib_next(sib_next), .imm_len(imm_len),
  .phase(phase), .out_vld(out_vld), .mrm_q(mrm_q)
);

// File: tb/test_mrm_len_resolver.sv
module test_mrm_len_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mrm_vld = 1'b0, sib_vld = 1'b0;
  logic [7:0] mrm_byte = '0, sib_byte = '0, opcode = '0;
  logic [1:0] addr_sz = '0, op_map = '0;
  logic [3:0] opnd_sz = 4'd4, imm_in = '0;
  logic [3:0] disp_len, imm_len;
  logic       sib_next, out_vld;
  logic [1:0] phase;
  logic [7:0] mrm_q;

  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  mrm_len_resolver i_mrm_len_resolver (
    .clk(clk), .rst(rst), .mrm_vld(mrm_vld), .mrm_byte(mrm_byte),
    .sib_vld(sib_vld), .sib_byte(sib_byte), .addr_sz(addr_sz),
    .op_map(op_map), .opcode(opcode), .opnd_sz(opnd_sz), .imm_in(imm_in),
    .disp_len(disp_len), .sib_next(sib_next), .imm_len(imm_len),
    .phase(phase), .out_vld(out_vld), .mrm_q(mrm_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [3:0] f_disp(logic [7:0] m, logic [1:0] asz);
    logic [1:0] md = m[7:6];
    logic [2:0] rm = m[2:0];
    if (asz == 2'd0) begin      // R1
      if (md == 2 || (md == 0 && rm == 6)) return 4'd2;
      if (md == 1) return 4'd1;
      return 4'd0;
    end
    if (md == 2 || (md == 0 && rm == 5)) return 4'd4;  // R2
    if (md == 1) return 4'd1;
    return 4'd0;
  endfunction

  function automatic logic f_sib(logic [7:0] m, logic [1:0] asz);
    return m[2:0] == 3'd4 && m[7:6] != 2'd3 && asz != 2'd0;  // R3
  endfunction

  function automatic logic [3:0] f_imm(logic [1:0] mp, logic [7:0] op,
                                       logic [7:0] m, logic [3:0] os, logic [3:0] ii);
    if (mp == 0 && m[5:4] == 2'b00) begin
      if (op == 8'hF6) return 4'd1;                        // R5
      if (op == 8'hF7) return (os == 4'd8) ? 4'd4 : os;    // R6
    end
    return ii;
  endfunction

  function automatic logic [1:0] f_ph(logic s, logic [3:0] d, logic [3:0] i);
    if (s) return 2'd1;          // R7
    if (d != 0) return 2'd2;
    if (i != 0) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [3:0] e_disp, e_imm;
  logic       e_sib;
  logic [1:0] e_ph;

  task automatic send_mrm(logic [7:0] m, logic [1:0] asz, logic [1:0] mp,
                          logic [7:0] op, logic [3:0] os, logic [3:0] ii);
    mrm_byte = m; addr_sz = asz; op_map = mp; opcode = op; opnd_sz = os; imm_in = ii;
    mrm_vld = 1'b1;
    @(negedge clk);
    mrm_vld = 1'b0;
    e_disp = f_disp(m, asz);
    e_sib  = f_sib(m, asz);
    e_imm  = f_imm(mp, op, m, os, ii);
    e_ph   = f_ph(e_sib, e_disp, e_imm);
    chk("R1/R2 disp", disp_len, e_disp);
    chk("R3 sib", sib_next, e_sib);
    chk("R5/R6 imm", imm_len, e_imm);
    chk("R7 phase", phase, e_ph);
    chk("R8 vld", out_vld, 1);
    chk("R8 latch", mrm_q, m);
  endtask

  task automatic send_sib(logic [7:0] s);
    sib_byte = s; sib_vld = 1'b1;
    @(negedge clk);
    sib_vld = 1'b0;
    if (mrm_q[7:6] == 2'd0 && s[2:0] == 3'd5) e_disp = 4'd4;  // R4
    e_sib = 1'b0;
    e_ph = f_ph(1'b0, e_disp, e_imm);
    chk("R4 disp", disp_len, e_disp);
    chk("R4 sib", sib_next, 0);
    chk("R7 phase after sib", phase, e_ph);
    chk("R8 vld sib", out_vld, 1);
    @(negedge clk);
    chk("R8 single pulse", out_vld, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 rst disp", disp_len, 0);
    chk("R9 rst phase", phase, 0);
    chk("R9 rst vld", out_vld, 0);
    chk("R9 rst mrm", mrm_q, 0);

    // directed R1: 16-bit mod0 rm6
    send_mrm(8'b00_000_110, 2'd0, 2'd1, 8'h8B, 4'd2, 4'd0);
    // R2 mod0 rm5 64-bit
    send_mrm(8'b00_000_101, 2'd2, 2'd1, 8'h8B, 4'd8, 4'd0);
    // R6 F7 with 8-byte operand
    send_mrm(8'b11_000_001, 2'd2, 2'd0, 8'hF7, 4'd8, 4'd0);
    // R5 F6 reg=1 also widened
    send_mrm(8'b11_001_001, 2'd1, 2'd0, 8'hF6, 4'd4, 4'd0);
    // R6 F7 reg=2 passes through
    send_mrm(8'b11_010_001, 2'd1, 2'd0, 8'hF7, 4'd4, 4'd0);
    // R9 stray SIB strobe in non-SIB phase
    sib_byte = 8'h05; sib_vld = 1'b1;
    @(negedge clk);
    sib_vld = 1'b0;
    chk("R9 stray vld", out_vld, 0);
    chk("R9 stray disp", disp_len, e_disp);
    chk("R9 stray phase", phase, e_ph);
    // R4 SIB with base5, mod0
    send_mrm(8'b00_000_100, 2'd1, 2'd1, 8'h10, 4'd4, 4'd1);
    send_sib(8'b01_010_101);
    // R4 base5 with mod1 keeps 1
    send_mrm(8'b01_000_100, 2'd2, 2'd1, 8'h10, 4'd4, 4'd0);
    send_sib(8'b00_000_101);
    // R3 16-bit rm4 no SIB
    send_mrm(8'b10_000_100, 2'd0, 2'd0, 8'h01, 4'd2, 4'd0);
    // R9 SIB strobe together with a new addressing byte in SIB phase
    send_mrm(8'b00_000_100, 2'd1, 2'd1, 8'h10, 4'd4, 4'd0);
    sib_byte = 8'h05; sib_vld = 1'b1;
    send_mrm(8'b11_000_000, 2'd1, 2'd1, 8'h10, 4'd4, 4'd0);
    sib_vld = 1'b0;

    for (int n = 0; n < 400; n++) begin
      logic [7:0] m = 8'($urandom);
      logic [7:0] op = ($urandom % 3 == 0) ? 8'hF6 : (($urandom % 2 == 0) ? 8'hF7 : 8'($urandom));
      logic [3:0] os = 4'(1 << ($urandom % 4));
      logic [3:0] ii = ($urandom % 2 == 0) ? 4'd0 : 4'(1 << ($urandom % 4));
      if ($urandom % 3 == 0) m[2:0] = 3'd4;
      send_mrm(m, 2'($urandom % 3), 2'($urandom % 4), op, os, ii);
      if (e_sib) begin
        logic [7:0] s = 8'($urandom);
        if ($urandom % 2 == 0) s[2:0] = 3'd5;
        send_sib(s);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule